// File: doc/BRIEF.md
# SPI Transmit/Receive Frame FIFO Pair

This block holds the frames that move between a serial peripheral engine and the rest of the chip. It contains two independent synchronous FIFOs. One queues words that wait to be shifted out. The other queues words that have been shifted in. Each side has push and pop strobes, full and empty flags, an entry counter, an overflow indication and a flush strobe. A flush empties its FIFO in one cycle. It zeroes the entry counter and both pointers, and the flush command itself is never stored, so it always reads back as zero.

The receive FIFO has a run-time unit-depth mode. While that mode is selected, the FIFO counts as full once it holds one entry. The mode input is registered. The new capacity applies from the clock edge that samples it. Words already stored are kept and can still be popped.

Each FIFO is controlled by a three-state occupancy machine:

- States:
  - EMPTY: nothing stored.
  - PART: holds some words but is below capacity.
  - FULL: at or above capacity.
- Transitions, evaluated at every edge from the next count and the next capacity:
  - EMPTY->PART: push.
  - PART->FULL: push that reaches capacity.
  - FULL->PART: pop.
  - PART->EMPTY: pop of the last word.
  - EMPTY->FULL: push while the capacity is one.
  - any state->EMPTY: flush.
  - PART->FULL with no push: the capacity drops to one while words are stored.

A constant configuration word reports both implemented depths.

Top module: `spi_fifo_pair`

## Requirements
- R1: After reset both FIFOs are empty, not full, with count 0. The receive unit-depth mode reads 0.
- R2: Words leave each FIFO in the order they were pushed. The count rises by one per accepted push and falls by one per pop.
- R3: With unit-depth mode off, a FIFO reports full exactly when its count equals its depth (default 4).
- R4: A push into a full FIFO is dropped. The count and stored words are unchanged, and the overflow output is high combinationally during that push.
- R5: With unit-depth mode on, the receive FIFO is full at one entry. A further push is dropped and raises overflow.
- R6: A transmit flush forces the transmit count to 0 at the next edge, even when a push and a pop occur in the same cycle.
- R7: A receive flush forces the receive count to 0 at the next edge, even when a push and a pop occur in the same cycle.
- R8: After a flush, the head of the FIFO is the first word pushed after the flush.
- R9: Changing the unit-depth mode keeps the words already stored. The new capacity governs only later pushes.
- R10: ctrl_readback bit 0 is the registered unit-depth mode. Bits 1 (transmit clear) and 2 (receive clear) always read 0, even while a flush strobe is high.
- R11: cfg_word bits [7:0] hold the transmit depth and bits [15:8] hold the receive depth.
- R12: A pop on an empty FIFO has no effect. The count stays 0.
- R13: A simultaneous push and pop on a partly filled FIFO keeps the count and advances the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_push | input | 1 | Write tx_wdata into the transmit FIFO |
| tx_wdata | input | DATA_W | Transmit write data |
| tx_pop | input | 1 | Remove the transmit head word |
| tx_rdata | output | DATA_W | Transmit head word |
| tx_flush | input | 1 | Write-one clear of the transmit FIFO |
| tx_full | output | 1 | Transmit FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_count | output | TX_CNT_W | Transmit entry count |
| tx_overflow | output | 1 | Transmit push being dropped |
| rx_push | input | 1 | Write rx_wdata into the receive FIFO |
| rx_wdata | input | DATA_W | Receive write data |
| rx_pop | input | 1 | Remove the receive head word |
| rx_rdata | output | DATA_W | Receive head word |
| rx_flush | input | 1 | Write-one clear of the receive FIFO |
| rx_unit_mode | input | 1 | Collapse the receive FIFO to unit depth |
| rx_full | output | 1 | Receive FIFO full |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_count | output | RX_CNT_W | Receive entry count |
| rx_overflow | output | 1 | Receive push being dropped |
| ctrl_readback | output | 3 | {rx clear, tx clear, unit mode} as read |
| cfg_word | output | 16 | {receive depth, transmit depth} |

## Verification
The transmit FIFO is driven through a table of push-only, push-and-pop, push-into-full and pop-past-empty cycles. This separates correct ordering from correct counting, and separates dropped pushes from accepted ones. Flushes are combined with a simultaneous push and pop, which shows whether the flush really has priority and whether the pointers restart. The receive side is filled, switched to unit depth while holding three words, drained, and refilled. This shows that stored words survive the switch and that the one-entry limit applies only to new pushes.

// File: rtl/spf_pkg.sv
package spf_pkg;

    // Occupancy state of one FIFO
    typedef enum logic [1:0] {
        FS_EMPTY = 2'd0,
        FS_PART  = 2'd1,
        FS_FULL  = 2'd2
    } fifo_state_e;

    // Width of each depth field in the configuration word
    localparam int CFG_FIELD_W = 8;

endpackage

// File: rtl/spf_fifo.sv
module spf_fifo
    import spf_pkg::*;
#(
    parameter  int DATA_W = 16,
    parameter  int DEPTH  = 4,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    input  logic              flush,
    input  logic              limit_one,   // capacity from the next edge on
    output logic              full,
    output logic              empty,
    output logic [CNT_W-1:0]  count,
    output logic              overflow
);

    fifo_state_e       state_q, state_d;
    logic [CNT_W-1:0]  count_q, count_d;
    logic [CNT_W-1:0]  cap;
    logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
    logic              do_push, do_pop;
    logic [DATA_W-1:0] mem [DEPTH];

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign cap = limit_one ? CNT_W'(1) : CNT_W'(DEPTH);

    // Transition process: accepted moves, next count, next state
    always_comb begin
        do_push = 1'b0;
        do_pop  = 1'b0;
        unique case (state_q)
            FS_EMPTY: do_push = push;
            FS_PART: begin
                do_push = push;
                do_pop  = pop;
            end
            FS_FULL:  do_pop  = pop;
            default: ;
        endcase
        if (flush) begin
            do_push = 1'b0;
            do_pop  = 1'b0;
        end
        count_d = count_q + CNT_W'(do_push) - CNT_W'(do_pop);
        if (flush) count_d = '0;
        if (count_d == '0)       state_d = FS_EMPTY;
        else if (count_d >= cap) state_d = FS_FULL;
        else                     state_d = FS_PART;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= FS_EMPTY;
            count_q  <= '0;
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
            if (flush) begin
                wr_ptr_q <= '0;
                rd_ptr_q <= '0;
            end else begin
                if (do_push) wr_ptr_q <= ptr_inc(wr_ptr_q);
                if (do_pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr_q] <= wdata;
    end

    // Output process
    always_comb begin
        empty    = 1'b0;
        full     = 1'b0;
        overflow = 1'b0;
        unique case (state_q)
            FS_EMPTY: empty = 1'b1;
            FS_PART: ;
            FS_FULL: begin
                full     = 1'b1;
                overflow = push & ~flush;
            end
            default: ;
        endcase
    end

    assign count = count_q;
    assign rdata = mem[rd_ptr_q];

    // R6 and R7: a flush leaves the count at zero
    a_r6_flush_zero: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));

    // R4: a dropped push without a pop keeps the count
    a_r4_drop_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !pop) |=> (count == $past(count)));

    // R2: the count never exceeds the depth
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    // R12: a pop on an empty FIFO leaves it empty
    a_r12_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty);

    // R13: push and pop together in PART keep the count
    a_r13_push_pop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty && !full && push && pop && !flush) |=> $stable(count));

endmodule

// File: rtl/spf_cfg_word.sv
module spf_cfg_word
    import spf_pkg::*;
#(
    parameter int TX_DEPTH = 4,
    parameter int RX_DEPTH = 4
) (
    output logic [2*CFG_FIELD_W-1:0] cfg
);

    initial begin
        a_r11_depth_fits: assert (TX_DEPTH < (1 << CFG_FIELD_W) && RX_DEPTH < (1 << CFG_FIELD_W));
    end

    assign cfg = {CFG_FIELD_W'(RX_DEPTH), CFG_FIELD_W'(TX_DEPTH)};

endmodule

// File: rtl/spi_fifo_pair.sv
module spi_fifo_pair
    import spf_pkg::*;
#(
    parameter  int DATA_W   = 16,
    parameter  int TX_DEPTH = 4,
    parameter  int RX_DEPTH = 4,
    localparam int TX_CNT_W = $clog2(TX_DEPTH + 1),
    localparam int RX_CNT_W = $clog2(RX_DEPTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tx_push,
    input  logic [DATA_W-1:0]        tx_wdata,
    input  logic                     tx_pop,
    output logic [DATA_W-1:0]        tx_rdata,
    input  logic                     tx_flush,
    output logic                     tx_full,
    output logic                     tx_empty,
    output logic [TX_CNT_W-1:0]      tx_count,
    output logic                     tx_overflow,
    input  logic                     rx_push,
    input  logic [DATA_W-1:0]        rx_wdata,
    input  logic                     rx_pop,
    output logic [DATA_W-1:0]        rx_rdata,
    input  logic                     rx_flush,
    input  logic                     rx_unit_mode,
    output logic                     rx_full,
    output logic                     rx_empty,
    output logic [RX_CNT_W-1:0]      rx_count,
    output logic                     rx_overflow,
    output logic [2:0]               ctrl_readback,
    output logic [2*CFG_FIELD_W-1:0] cfg_word
);

    logic rx_mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_mode_q <= 1'b0;
        else        rx_mode_q <= rx_unit_mode;
    end

    spf_fifo #(.DATA_W(DATA_W), .DEPTH(TX_DEPTH)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (tx_push),
        .wdata    (tx_wdata),
        .pop      (tx_pop),
        .rdata    (tx_rdata),
        .flush    (tx_flush),
        .limit_one(1'b0),
        .full     (tx_full),
        .empty    (tx_empty),
        .count    (tx_count),
        .overflow (tx_overflow)
    );

    spf_fifo #(.DATA_W(DATA_W), .DEPTH(RX_DEPTH)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (rx_push),
        .wdata    (rx_wdata),
        .pop      (rx_pop),
        .rdata    (rx_rdata),
        .flush    (rx_flush),
        .limit_one(rx_unit_mode),
        .full     (rx_full),
        .empty    (rx_empty),
        .count    (rx_count),
        .overflow (rx_overflow)
    );

    spf_cfg_word #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_cfg (
        .cfg(cfg_word)
    );

    // Clear commands are strobes and are never held
    assign ctrl_readback = {1'b0, 1'b0, rx_mode_q};

    // R5: in unit-depth mode any stored word makes the receive side full
    a_r5_unit_full: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_mode_q && rx_count != '0) |-> rx_full);

    // R9: a mode change alone never drops stored words
    a_r9_mode_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_unit_mode != rx_mode_q && !rx_pop && !rx_flush) |=> (rx_count >= $past(rx_count)));

endmodule

// File: tb/spi_fifo_pair_test.sv
module spi_fifo_pair_test;

    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tx_push = 0, tx_pop = 0, tx_flush = 0;
    logic [DW-1:0] tx_wdata = '0;
    logic          rx_push = 0, rx_pop = 0, rx_flush = 0, rx_unit_mode = 0;
    logic [DW-1:0] rx_wdata = '0;
    logic [DW-1:0] tx_rdata, rx_rdata;
    logic          tx_full, tx_empty, tx_overflow;
    logic          rx_full, rx_empty, rx_overflow;
    logic [2:0]    tx_count, rx_count;
    logic [2:0]    ctrl_readback;
    logic [15:0]   cfg_word;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    spi_fifo_pair uut (
        .clk(clk), .rst_n(rst_n),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
        .tx_flush(tx_flush), .tx_full(tx_full), .tx_empty(tx_empty),
        .tx_count(tx_count), .tx_overflow(tx_overflow),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
        .rx_flush(rx_flush), .rx_unit_mode(rx_unit_mode), .rx_full(rx_full),
        .rx_empty(rx_empty), .rx_count(rx_count), .rx_overflow(rx_overflow),
        .ctrl_readback(ctrl_readback), .cfg_word(cfg_word)
    );

    // {push, pop, wdata, expected count, expected head}
    localparam logic [37:0] TBL [11] = '{
        {1'b1, 1'b0, 16'hA001, 4'd1, 16'hA001},
        {1'b1, 1'b0, 16'hA002, 4'd2, 16'hA001},
        {1'b1, 1'b1, 16'hA003, 4'd2, 16'hA002},
        {1'b1, 1'b0, 16'hA004, 4'd3, 16'hA002},
        {1'b1, 1'b0, 16'hA005, 4'd4, 16'hA002},
        {1'b1, 1'b0, 16'hA006, 4'd4, 16'hA002},
        {1'b0, 1'b1, 16'h0000, 4'd3, 16'hA003},
        {1'b0, 1'b1, 16'h0000, 4'd2, 16'hA004},
        {1'b0, 1'b1, 16'h0000, 4'd1, 16'hA005},
        {1'b0, 1'b1, 16'h0000, 4'd0, 16'h0000},
        {1'b0, 1'b1, 16'h0000, 4'd0, 16'h0000}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic rx_put(input logic [DW-1:0] d);
        rx_push = 1; rx_wdata = d;
        step();
        rx_push = 0;
    endtask

    task automatic rx_take();
        rx_pop = 1;
        step();
        rx_pop = 0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int prev;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        step();

        // R1: reset state
        chk("R1 tx_empty", int'(tx_empty), 1);
        chk("R1 rx_empty", int'(rx_empty), 1);
        chk("R1 tx_count", int'(tx_count), 0);
        chk("R1 rx_count", int'(rx_count), 0);
        chk("R1 full", int'({tx_full, rx_full}), 0);
        chk("R1 mode", int'(ctrl_readback), 0);

        // R11: depth fields
        chk("R11 cfg_word", int'(cfg_word), 16'h0404);

        // Table walk on the transmit side (R2, R3, R4, R12, R13)
        prev = 0;
        for (int i = 0; i < 11; i++) begin
            tx_push  = TBL[i][37];
            tx_pop   = TBL[i][36];
            tx_wdata = TBL[i][35:20];
            #0.5;
            chk("R4 tx_overflow", int'(tx_overflow), int'(TBL[i][37] && prev == 4));
            step();
            tx_push = 0; tx_pop = 0;
            chk("R2 tx_count", int'(tx_count), int'(TBL[i][19:16]));
            chk("R3 tx_full", int'(tx_full), int'(TBL[i][19:16] == 4));
            chk("R12 tx_empty", int'(tx_empty), int'(TBL[i][19:16] == 0));
            if (TBL[i][19:16] != 0)
                chk("R13 tx_head", int'(tx_rdata), int'(TBL[i][15:0]));
            prev = int'(TBL[i][19:16]);
        end

        // R6 and R8: flush with simultaneous push and pop
        for (int k = 0; k < 3; k++) begin
            tx_push = 1; tx_wdata = 16'hB000 + 16'(k);
            step();
        end
        tx_push = 1; tx_pop = 1; tx_flush = 1; tx_wdata = 16'hBBBB;
        #0.5;
        chk("R10 clear bits while flushing", int'(ctrl_readback[2:1]), 0);
        step();
        tx_pop = 0; tx_flush = 0; tx_wdata = 16'hB009;
        chk("R6 tx_count after flush", int'(tx_count), 0);
        chk("R6 tx_empty after flush", int'(tx_empty), 1);
        step();
        tx_push = 0;
        chk("R8 tx head after flush", int'(tx_rdata), 16'hB009);
        chk("R8 tx_count", int'(tx_count), 1);

        // R3 and R7: receive full depth, then flush with push and pop
        for (int k = 0; k < 4; k++) rx_put(16'hC100 + 16'(k));
        chk("R3 rx_full at depth", int'(rx_full), 1);
        rx_push = 1; rx_pop = 1; rx_flush = 1; rx_wdata = 16'hCCCC;
        step();
        rx_push = 0; rx_pop = 0; rx_flush = 0;
        chk("R7 rx_count after flush", int'(rx_count), 0);
        chk("R10 clear bits after flush", int'(ctrl_readback), 0);
        rx_put(16'hD001);
        rx_put(16'hD002);
        chk("R8 rx head after flush", int'(rx_rdata), 16'hD001);

        // R12: pop on empty
        rx_flush = 1; step(); rx_flush = 0;
        rx_take();
        chk("R12 rx_count on empty pop", int'(rx_count), 0);
        chk("R12 rx_empty on empty pop", int'(rx_empty), 1);

        // R9 and R5: switch to unit depth with three words stored
        rx_put(16'hE001);
        rx_put(16'hE002);
        rx_put(16'hE003);
        rx_unit_mode = 1;
        step();
        chk("R10 mode readback", int'(ctrl_readback), 1);
        chk("R9 words kept", int'(rx_count), 3);
        chk("R9 full after switch", int'(rx_full), 1);
        rx_push = 1; rx_wdata = 16'hEEEE;
        #0.5;
        chk("R5 overflow on switched FIFO", int'(rx_overflow), 1);
        step();
        rx_push = 0;
        chk("R9 count after dropped push", int'(rx_count), 3);
        chk("R9 head kept", int'(rx_rdata), 16'hE001);
        rx_take();
        chk("R9 second word", int'(rx_rdata), 16'hE002);
        rx_take();
        chk("R9 third word", int'(rx_rdata), 16'hE003);
        chk("R5 still full with one", int'(rx_full), 1);
        rx_take();
        chk("R9 drained", int'(rx_empty), 1);
        rx_put(16'hF001);
        chk("R5 full at one", int'(rx_full), 1);
        chk("R5 count one", int'(rx_count), 1);
        rx_push = 1; rx_wdata = 16'hF002;
        #0.5;
        chk("R5 overflow at one", int'(rx_overflow), 1);
        step();
        rx_push = 0;
        chk("R5 count stays one", int'(rx_count), 1);
        chk("R5 head kept", int'(rx_rdata), 16'hF001);

        // R9: back to full depth, later pushes use it
        rx_unit_mode = 0;
        step();
        chk("R9 not full at one", int'(rx_full), 0);
        rx_put(16'hF003);
        chk("R9 count grows", int'(rx_count), 2);
        chk("R9 full depth", int'(rx_full), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule